// File: doc/BRIEF.md
# Event-Triggered Descriptor Transfer Controller

This block moves bytes across a shared 16-bit memory bus without CPU involvement. Peripheral events start it. Each source has an enable bit. An enabled event is latched as pending. When the block is idle, it takes the lowest-numbered pending source and picks that source's descriptor slot. It reads the 8-byte descriptor from a reserved memory area, then moves one block of bytes, one read and one write per byte. After the block it writes the changed counter and address bytes back to the descriptor, and it may pulse the source's interrupt line toward the CPU.

Two modes exist. In normal mode the per-activation count runs down, and the activation that takes it from 1 to 0 always interrupts. In repeat mode that same activation rewinds the address on the chosen repeat side to its start and reloads the count, so the descriptor keeps cycling. An interrupt fires on that wrap only when the descriptor asks for it. The block drives a request and waits for a grant. The grant logic outside gives the controller precedence over the CPU.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset no bus request is driven, no interrupt line is high and nothing is pending.
- R2: An event is latched only while its enable bit is 1. An event on a disabled source causes no bus access. A pending source whose enable drops before it is served is discarded and never served.
- R3: Among pending sources the lowest-numbered one is served first. Source s uses descriptor slot s mod NUM_DESC, located at DESC_BASE + 8 × slot. A source's pending flag clears when its activation ends.
- R4: Each activation begins with eight reads of its descriptor, in byte order 0 to 7, before any data access. Byte layout: 0 mode, 1 block size, 2 count, 3 reload, 4/5 source address low/high, 6/7 destination address low/high. Mode bits: bit0 repeat mode, bit1 repeat side is the destination (0 = source), bit2 source increments, bit3 destination increments, bit4 repeat interrupt enable.
- R5: One activation moves block-size bytes, where a block size of 0 means 256. Each byte is a read at the source address followed by a write to the destination address. After each byte, each address either increments or stays fixed, as its mode bit selects.
- R6: After the block, the descriptor bytes 2 to 7 are written back in that order, holding the updated count, reload and addresses. The count decrements by one per activation, and a count of 0 stands for 256.
- R7: In normal mode, an activation that starts with count 1 writes back count 0. One cycle after the last write-back byte, it pulses that source's interrupt line for exactly one cycle. Other activations raise no interrupt.
- R8: In repeat mode, an activation that starts with count 1 reloads the count from the reload byte. If the repeat side increments, its address moves back by reload × block size, which returns it to its start. The other side keeps advancing.
- R9: In repeat mode the count wrap raises the interrupt pulse only when mode bit4 is 1.
- R10: While the grant is low, the request, address, write flag and write data stay unchanged. An access completes in a cycle where request and grant are both high, and read data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | NUM_SRC | Event pulses, one per source |
| en_i | input | NUM_SRC | Per-source activation enable |
| bus_req_o | output | 1 | Bus request; held until granted |
| bus_gnt_i | input | 1 | Bus grant; the access completes in a granted cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 16 | Byte address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid in the granted cycle |
| irq_o | output | NUM_SRC | One-cycle interrupt pulse per source |

## Verification
The bench sweeps block sizes 1 to 4 against all four fixed/increment combinations. A design that moved the wrong address or skipped a step would leave wrong bytes at the destination or wrong addresses in the written-back descriptor. Repeat mode is checked with the repeat side on each end, with and without the interrupt enable. A design that rewound the wrong side, or rewound by the wrong span, would leave a wrong address in the descriptor. One that ignored bit4 would show an extra or missing pulse. Other tests check that a block size of 0 moves 256 bytes and that the bus trace shows fetch, move and write-back in order. They also check that the lower source wins a tie, that a source above NUM_DESC wraps to the right slot, that disabled or withdrawn events stay silent, and that a stalling grant leaves the results unchanged.

// File: rtl/evx_pkg.sv
package evx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRD,
        S_XRD,
        S_XWR,
        S_DWB,
        S_DONE
    } evx_st_e;

    // mode byte bit positions
    localparam int M_RPT  = 0;
    localparam int M_RDST = 1;
    localparam int M_SINC = 2;
    localparam int M_DINC = 3;
    localparam int M_RIE  = 4;

    // descriptor byte offsets
    localparam logic [2:0] D_MODE = 3'd0;
    localparam logic [2:0] D_BLK  = 3'd1;
    localparam logic [2:0] D_CNT  = 3'd2;
    localparam logic [2:0] D_RLD  = 3'd3;
    localparam logic [2:0] D_SAL  = 3'd4;
    localparam logic [2:0] D_SAH  = 3'd5;
    localparam logic [2:0] D_DAL  = 3'd6;
    localparam logic [2:0] D_DAH  = 3'd7;

endpackage

// File: rtl/evx_pend.sv
module evx_pend #(
    parameter int NUM_SRC = 33,
    localparam int SW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev,
    input  logic [NUM_SRC-1:0] en,
    input  logic               clr,
    input  logic [SW-1:0]      clr_idx,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               any_o,
    output logic [SW-1:0]      sel_o
);

    logic [NUM_SRC-1:0] pend_d, pend_q;
    logic [NUM_SRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr) begin
            clr_mask[clr_idx] = 1'b1;
        end
        pend_d = (pend_q & en & ~clr_mask) | (ev & en);

        sel_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel_o = SW'(i);
            end
        end
        any_o = |pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R2: a flag never survives a cycle in which its enable was low
    a_r2_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(en)) == '0));

    // R3: the chosen source is really pending
    a_r3_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> pend_q[sel_o]);

endmodule

// File: rtl/evx_engine.sv
module evx_engine
    import evx_pkg::*;
#(
    parameter int          NUM_SRC   = 33,
    parameter int          NUM_DESC  = 24,
    parameter logic [15:0] DESC_BASE = 16'h0F00,
    localparam int SW = $clog2(NUM_SRC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_any,
    input  logic [SW-1:0] req_idx,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          bus_we,
    output logic [15:0]   bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    output logic          done_v,
    output logic [SW-1:0] done_idx,
    output logic          irq_v
);

    typedef struct packed {
        evx_st_e       st;
        logic [SW-1:0] src;
        logic [15:0]   dba;
        logic [2:0]    bi;
        logic [7:0]    mode;
        logic [7:0]    blk;
        logic [7:0]    cnt;
        logic [7:0]    rld;
        logic [15:0]   sa;
        logic [15:0]   da;
        logic [8:0]    left;
        logic [7:0]    dbuf;
        logic          fire;
    } eng_s;

    eng_s q, d;

    logic [8:0]  blk_e, rld_e;
    logic [15:0] span, sa_n, da_n, slot_ofs;

    always_comb begin
        blk_e    = (q.blk == 8'd0) ? 9'd256 : {1'b0, q.blk};
        rld_e    = (q.rld == 8'd0) ? 9'd256 : {1'b0, q.rld};
        span     = 16'({7'd0, rld_e} * {7'd0, blk_e});
        sa_n     = q.sa + {15'd0, q.mode[M_SINC]};
        da_n     = q.da + {15'd0, q.mode[M_DINC]};
        slot_ofs = 16'((32'(req_idx) % NUM_DESC) * 8);

        d = q;
        unique case (q.st)
            S_IDLE: begin
                d.fire = 1'b0;
                if (req_any) begin
                    d.st  = S_DRD;
                    d.src = req_idx;
                    d.dba = DESC_BASE + slot_ofs;
                    d.bi  = 3'd0;
                end
            end
            S_DRD: begin
                if (bus_gnt) begin
                    case (q.bi)
                        D_MODE:  d.mode       = bus_rdata;
                        D_BLK:   d.blk        = bus_rdata;
                        D_CNT:   d.cnt        = bus_rdata;
                        D_RLD:   d.rld        = bus_rdata;
                        D_SAL:   d.sa[7:0]    = bus_rdata;
                        D_SAH:   d.sa[15:8]   = bus_rdata;
                        D_DAL:   d.da[7:0]    = bus_rdata;
                        default: d.da[15:8]   = bus_rdata;
                    endcase
                    if (q.bi == D_DAH) begin
                        d.st   = S_XRD;
                        d.left = blk_e;
                    end else begin
                        d.bi = q.bi + 3'd1;
                    end
                end
            end
            S_XRD: begin
                if (bus_gnt) begin
                    d.dbuf = bus_rdata;
                    d.st   = S_XWR;
                end
            end
            S_XWR: begin
                if (bus_gnt) begin
                    d.sa   = sa_n;
                    d.da   = da_n;
                    d.left = q.left - 9'd1;
                    if (q.left == 9'd1) begin
                        d.st = S_DWB;
                        d.bi = D_CNT;
                        if (q.cnt == 8'd1) begin
                            d.fire = q.mode[M_RPT] ? q.mode[M_RIE] : 1'b1;
                            if (q.mode[M_RPT]) begin
                                d.cnt = q.rld;
                                if (q.mode[M_RDST]) begin
                                    if (q.mode[M_DINC]) d.da = da_n - span;
                                end else begin
                                    if (q.mode[M_SINC]) d.sa = sa_n - span;
                                end
                            end else begin
                                d.cnt = 8'd0;
                            end
                        end else begin
                            d.cnt  = q.cnt - 8'd1;
                            d.fire = 1'b0;
                        end
                    end else begin
                        d.st = S_XRD;
                    end
                end
            end
            S_DWB: begin
                if (bus_gnt) begin
                    if (q.bi == D_DAH) begin
                        d.st = S_DONE;
                    end else begin
                        d.bi = q.bi + 3'd1;
                    end
                end
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_req   = (q.st == S_DRD) || (q.st == S_XRD) || (q.st == S_XWR) || (q.st == S_DWB);
        bus_we    = (q.st == S_XWR) || (q.st == S_DWB);
        bus_addr  = q.dba + {13'd0, q.bi};
        bus_wdata = q.dbuf;
        case (q.st)
            S_XRD:   bus_addr = q.sa;
            S_XWR:   bus_addr = q.da;
            default: bus_addr = q.dba + {13'd0, q.bi};
        endcase
        if (q.st == S_DWB) begin
            case (q.bi)
                D_CNT:   bus_wdata = q.cnt;
                D_RLD:   bus_wdata = q.rld;
                D_SAL:   bus_wdata = q.sa[7:0];
                D_SAH:   bus_wdata = q.sa[15:8];
                D_DAL:   bus_wdata = q.da[7:0];
                D_DAH:   bus_wdata = q.da[15:8];
                default: bus_wdata = q.mode;
            endcase
        end
    end

    assign done_v   = (q.st == S_DONE);
    assign done_idx = q.src;
    assign irq_v    = (q.st == S_DONE) && q.fire;

    // R10: an ungranted access is presented again unchanged
    a_r10_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    // R5: a data access is only ever made with bytes still owed
    a_r5_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == S_XRD) || (q.st == S_XWR)) |-> (q.left != 9'd0));

    // R4: data movement is entered only straight from the last descriptor byte
    a_r4_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == S_XRD) && ($past(q.st) != S_XRD) && ($past(q.st) != S_XWR))
            |-> ($past(q.st) == S_DRD));

endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl #(
    parameter int          NUM_SRC   = 33,
    parameter int          NUM_DESC  = 24,
    parameter logic [15:0] DESC_BASE = 16'h0F00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               bus_req_o,
    input  logic               bus_gnt_i,
    output logic               bus_we_o,
    output logic [15:0]        bus_addr_o,
    output logic [7:0]         bus_wdata_o,
    input  logic [7:0]         bus_rdata_i,
    output logic [NUM_SRC-1:0] irq_o
);

    localparam int SW = $clog2(NUM_SRC);

    logic               any;
    logic [SW-1:0]      sel;
    logic [NUM_SRC-1:0] pend;
    logic               done_v, irq_v;
    logic [SW-1:0]      done_idx;

    evx_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_i),
        .en      (en_i),
        .clr     (done_v),
        .clr_idx (done_idx),
        .pend_o  (pend),
        .any_o   (any),
        .sel_o   (sel)
    );

    evx_engine #(
        .NUM_SRC   (NUM_SRC),
        .NUM_DESC  (NUM_DESC),
        .DESC_BASE (DESC_BASE)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_any   (any && !done_v),
        .req_idx   (sel),
        .bus_req   (bus_req_o),
        .bus_gnt   (bus_gnt_i),
        .bus_we    (bus_we_o),
        .bus_addr  (bus_addr_o),
        .bus_wdata (bus_wdata_o),
        .bus_rdata (bus_rdata_i),
        .done_v    (done_v),
        .done_idx  (done_idx),
        .irq_v     (irq_v)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_irq
        assign irq_o[g] = irq_v && (done_idx == SW'(g));
    end

    // R7: at most one source interrupts at a time
    a_r7_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R7: an interrupt follows directly on a granted write-back
    a_r7_irq_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> $past(bus_req_o && bus_we_o && bus_gnt_i));

    // R1: nothing pending means no activity can start
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend == '0) && !bus_req_o) |=> !bus_req_o);

endmodule

// File: tb/sim_evt_xfer_ctrl.sv
module sim_evt_xfer_ctrl;

    localparam int          NS   = 33;
    localparam int          ND   = 24;
    localparam logic [15:0] BASE = 16'h0F00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] ev = '0;
    logic [NS-1:0] en = '1;
    logic          bus_req, bus_gnt, bus_we;
    logic [15:0]   bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic [NS-1:0] irq;

    always #2.5 clk = ~clk;

    evt_xfer_ctrl #(.NUM_SRC(NS), .NUM_DESC(ND), .DESC_BASE(BASE)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev),
        .en_i        (en),
        .bus_req_o   (bus_req),
        .bus_gnt_i   (bus_gnt),
        .bus_we_o    (bus_we),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_rdata_i (bus_rdata),
        .irq_o       (irq)
    );

    // memory model, 4 KiB aliased
    logic [7:0]  mem [4096];
    logic        hw_en = 1'b0;
    logic [11:0] hw_a = '0;
    logic [7:0]  hw_d = '0;
    always @(posedge clk) begin
        if (hw_en) mem[hw_a] <= hw_d;
        else if (bus_req && bus_gnt && bus_we) mem[bus_addr[11:0]] <= bus_wdata;
    end
    assign bus_rdata = mem[bus_addr[11:0]];

    // grant: always, or stalling two of every three cycles
    logic stall = 1'b0;
    int   gc = 0;
    always @(posedge clk) gc <= gc + 1;
    assign bus_gnt = !stall || ((gc % 3) == 0);

    // monitors
    int          irq_cnt [NS];
    int          ilog [16];
    int          ilen;
    logic [15:0] tr_a [64];
    logic        tr_we [64];
    int          tr_n;
    logic        tr_clr = 1'b0;
    initial for (int i = 0; i < NS; i++) irq_cnt[i] = 0;
    always @(negedge clk) begin
        if (tr_clr) begin
            tr_n = 0;
            ilen = 0;
        end else if (rst_n) begin
            for (int i = 0; i < NS; i++) begin
                if (irq[i]) begin
                    irq_cnt[i] = irq_cnt[i] + 1;
                    if (ilen < 16) ilog[ilen] = i;
                    ilen = ilen + 1;
                end
            end
            if (bus_req && bus_gnt) begin
                if (tr_n < 64) begin
                    tr_a[tr_n]  = bus_addr;
                    tr_we[tr_n] = bus_we;
                end
                tr_n = tr_n + 1;
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input string r, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic hw_wr(input int a, input int v);
        hw_en = 1'b1;
        hw_a  = 12'(a);
        hw_d  = 8'(v);
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    function automatic int dadr(input int slot, input int b);
        return int'(BASE) + slot * 8 + b;
    endfunction

    function automatic int rd16(input int a);
        return int'(mem[12'(a)]) + 256 * int'(mem[12'(a + 1)]);
    endfunction

    task automatic set_desc(input int slot, input int mode, input int blk, input int cnt,
                            input int rld, input int sa, input int da);
        hw_wr(dadr(slot, 0), mode);
        hw_wr(dadr(slot, 1), blk);
        hw_wr(dadr(slot, 2), cnt);
        hw_wr(dadr(slot, 3), rld);
        hw_wr(dadr(slot, 4), sa & 255);
        hw_wr(dadr(slot, 5), sa >> 8);
        hw_wr(dadr(slot, 6), da & 255);
        hw_wr(dadr(slot, 7), da >> 8);
    endtask

    task automatic pulse(input int s);
        ev[s] = 1'b1;
        @(negedge clk);
        ev[s] = 1'b0;
    endtask

    task automatic wait_quiet();
        int qc = 0;
        while (qc < 6) begin
            @(negedge clk);
            if (bus_req) qc = 0;
            else qc++;
        end
    endtask

    task automatic clr_trace();
        tr_clr = 1'b1;
        @(negedge clk);
        tr_clr = 1'b0;
    endtask

    function automatic int pat(input int seed, input int k);
        return (seed * 16 + k * 3 + 1) & 255;
    endfunction

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int i0, e0;
        repeat (4) @(negedge clk);
        chk("R1 req during reset", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after reset", int'(bus_req), 0);
        chk("R1 irq after reset", int'(irq != '0), 0);
        repeat (3) @(negedge clk);
        chk("R1 stays quiet", int'(bus_req), 0);

        // normal-mode sweep: block 1..4, each fixed/increment pairing (R5 R6 R7)
        for (int b = 1; b <= 4; b++) begin
            for (int si = 0; si < 2; si++) begin
                for (int di = 0; di < 2; di++) begin
                    for (int k = 0; k < 8; k++) hw_wr(16'h0100 + k, pat(b, k));
                    for (int k = 0; k < 8; k++) hw_wr(16'h0300 + k, 8'hEE);
                    set_desc(2, si * 4 + di * 8, b, 2, 0, 16'h0100, 16'h0300);
                    i0 = irq_cnt[2];
                    pulse(2);
                    wait_quiet();
                    if (di == 1) begin
                        for (int k = 0; k < b; k++)
                            chk("R5 dst byte", int'(mem[12'h300 + k]), pat(b, si == 1 ? k : 0));
                        chk("R5 dst beyond block", int'(mem[12'h300 + b]), 8'hEE);
                    end else begin
                        chk("R5 fixed dst", int'(mem[12'h300]), pat(b, si == 1 ? b - 1 : 0));
                        chk("R5 fixed dst next", int'(mem[12'h301]), 8'hEE);
                    end
                    chk("R6 count after first", int'(mem[12'(dadr(2, 2))]), 1);
                    chk("R6 src addr", rd16(dadr(2, 4)), 16'h0100 + si * b);
                    chk("R6 dst addr", rd16(dadr(2, 6)), 16'h0300 + di * b);
                    chk("R7 no irq mid count", irq_cnt[2] - i0, 0);
                    pulse(2);
                    wait_quiet();
                    chk("R7 count reaches 0", int'(mem[12'(dadr(2, 2))]), 0);
                    chk("R7 irq at end", irq_cnt[2] - i0, 1);
                    chk("R6 src addr 2", rd16(dadr(2, 4)), 16'h0100 + 2 * si * b);
                end
            end
        end

        // repeat mode: repeat side and interrupt enable swept (R8 R9)
        for (int rie = 0; rie < 2; rie++) begin
            for (int rd = 0; rd < 2; rd++) begin
                for (int k = 0; k < 12; k++) hw_wr(16'h0100 + k, pat(9, k));
                for (int k = 0; k < 12; k++) hw_wr(16'h0300 + k, 8'hEE);
                set_desc(2, 1 + rd * 2 + 4 + 8 + rie * 16, 3, 2, 2, 16'h0100, 16'h0300);
                i0 = irq_cnt[2];
                pulse(2);
                wait_quiet();
                pulse(2);
                wait_quiet();
                chk("R8 count reloaded", int'(mem[12'(dadr(2, 2))]), 2);
                chk("R8 repeat side rewound",
                    rd16(dadr(2, rd == 1 ? 6 : 4)), rd == 1 ? 16'h0300 : 16'h0100);
                chk("R8 other side advances",
                    rd16(dadr(2, rd == 1 ? 4 : 6)), rd == 1 ? 16'h0106 : 16'h0306);
                chk("R9 irq follows enable bit", irq_cnt[2] - i0, rie);
                pulse(2);
                wait_quiet();
                chk("R8 count after third", int'(mem[12'(dadr(2, 2))]), 1);
                chk("R9 no irq mid cycle", irq_cnt[2] - i0, rie);
                for (int k = 0; k < 9; k++) begin
                    e0 = (rd == 1) ? pat(9, k < 3 ? k + 6 : k) : pat(9, k % 6);
                    if (rd == 1 && k >= 6) e0 = 8'hEE;
                    chk("R8 data placement", int'(mem[12'h300 + k]), e0);
                end
            end
        end

        // disabled source and withdrawn pending (R2)
        en[4] = 1'b0;
        set_desc(4, 8'h0C, 1, 5, 0, 16'h0100, 16'h0340);
        clr_trace();
        pulse(4);
        repeat (20) @(negedge clk);
        chk("R2 disabled event no access", tr_n, 0);
        chk("R2 disabled desc untouched", int'(mem[12'(dadr(4, 2))]), 5);
        en[4] = 1'b1;
        set_desc(6, 8'h0C, 1, 3, 0, 16'h0100, 16'h0350);
        set_desc(7, 8'h0C, 1, 1, 0, 16'h0100, 16'h0360);
        i0 = irq_cnt[7];
        ev[6] = 1'b1;
        ev[7] = 1'b1;
        @(negedge clk);
        ev[6] = 1'b0;
        ev[7] = 1'b0;
        en[7] = 1'b0;
        wait_quiet();
        en[7] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 withdrawn source not served", irq_cnt[7] - i0, 0);
        chk("R2 withdrawn desc untouched", int'(mem[12'(dadr(7, 2))]), 1);
        chk("R2 enabled neighbour served", int'(mem[12'(dadr(6, 2))]), 2);

        // priority, fetch order and write-back order (R3 R4 R6)
        set_desc(3, 8'h0C, 1, 1, 0, 16'h0120, 16'h0320);
        set_desc(5, 8'h0C, 1, 1, 0, 16'h0130, 16'h0330);
        clr_trace();
        ev[5] = 1'b1;
        ev[3] = 1'b1;
        @(negedge clk);
        ev[5] = 1'b0;
        ev[3] = 1'b0;
        wait_quiet();
        chk("R3 two interrupts", ilen, 2);
        chk("R3 lower source first", ilog[0], 3);
        chk("R3 higher source second", ilog[1], 5);
        chk("R4 access count", tr_n, 32);
        for (int k = 0; k < 8; k++) begin
            chk("R4 descriptor read addr", int'(tr_a[k]), dadr(3, k));
            chk("R4 descriptor read dir", int'(tr_we[k]), 0);
        end
        chk("R5 source read", int'(tr_a[8]), 16'h0120);
        chk("R5 dest write", int'(tr_a[9]) + 1000 * int'(tr_we[9]), 16'h0320 + 1000);
        for (int k = 0; k < 6; k++)
            chk("R6 writeback order", int'(tr_a[10 + k]) + 1000 * int'(tr_we[10 + k]),
                dadr(3, k + 2) + 1000);
        chk("R4 second fetch slot", int'(tr_a[16]), dadr(5, 0));

        // slot wrap: source 29 uses slot 5 (R3)
        set_desc(5, 8'h0C, 1, 1, 0, 16'h0130, 16'h0330);
        i0 = irq_cnt[29];
        pulse(29);
        wait_quiet();
        chk("R3 wrapped source irq", irq_cnt[29] - i0, 1);
        chk("R3 wrapped slot count", int'(mem[12'(dadr(5, 2))]), 0);

        // stalling grant (R10)
        stall = 1'b1;
        for (int k = 0; k < 3; k++) hw_wr(16'h0140 + k, pat(5, k));
        set_desc(1, 8'h0C, 3, 3, 0, 16'h0140, 16'h0370);
        clr_trace();
        pulse(1);
        wait_quiet();
        stall = 1'b0;
        for (int k = 0; k < 3; k++)
            chk("R10 stalled data", int'(mem[12'h370 + k]), pat(5, k));
        chk("R10 stalled count", int'(mem[12'(dadr(1, 2))]), 2);
        chk("R10 stalled access count", tr_n, 20);

        // block size 0 means 256 (R5 R7)
        for (int k = 0; k < 256; k++) hw_wr(16'h0100 + k, (k ^ 8'h5A) & 255);
        set_desc(8, 8'h0C, 0, 1, 0, 16'h0100, 16'h0400);
        i0 = irq_cnt[8];
        pulse(8);
        wait_quiet();
        e0 = 0;
        for (int k = 0; k < 256; k++)
            if (int'(mem[12'h400 + k]) != ((k ^ 8'h5A) & 255)) e0++;
        chk("R5 256-byte block mismatches", e0, 0);
        chk("R5 256-byte dst end", rd16(dadr(8, 6)), 16'h0500);
        chk("R5 256-byte src end", rd16(dadr(8, 4)), 16'h0200);
        chk("R7 256-byte irq", irq_cnt[8] - i0, 1);

        finish_run();
    end

endmodule